// File: doc/BRIEF.md
# Z80 Debug Paging Controller

This block watches the bus of a Z80 host system and decides when a 16 KB debug RAM takes the place of the system ROM in the bottom 16 KB of the memory map. The switch to the debug RAM, called paged in here, happens on an opcode fetch from address zero. Because a single-byte restart-to-zero instruction planted in a program lands there, this acts as a software breakpoint trap. The switch also happens on an I/O read of the page-control port. An I/O write to the same port, or optionally an opcode fetch from the 16–32 KB region, switches back to the system ROM. A second I/O port is decoded as a data channel between the debugger and the Z80 program, and it leaves the paging state alone.

Nothing can page in until a host-side controller sets the arm latch. The latch is clear after reset. When the host clears the latch, the block is forced out of the paged state at once.

The bus strobes are synchronised into the block's clock domain, and paging acts once per bus cycle on the detected falling edge. The chip selects are combinational from the live bus, so that memory timing is kept.

Top module: `z80_page_ctrl`

## Requirements
- R1: After reset the block is disarmed and paged out. `ram_sel_n` is 1 and `rom_sel_n_out` equals `rom_sel_n_in`.
- R2: While disarmed, no bus event sets `paged`.
- R3: When armed, an opcode fetch with M1 low, IORQ high and address 0x0000 sets `paged` 3 clock edges after the strobe is applied.
- R4: When armed, an I/O read (IORQ low, RD low, M1 high) whose A7:A0 equals 0x9F sets `paged`.
- R5: An I/O write (IORQ low, WR low, M1 high) whose A7:A0 equals 0x9F clears `paged`.
- R6: An I/O read or write with A7:A0 equal to 0x3F and M1 high drives `comm_sel` high while it lasts and leaves `paged` unchanged.
- R7: `ram_sel_n` is low only while paged, MREQ is low and A15:A14 is 00. In the window 0x0000–0x3FFF, `rom_sel_n_out` is 1 while paged.
- R8: For addresses with A15:A14 not 00, `rom_sel_n_out` equals `rom_sel_n_in` even while paged.
- R9: With `exit_hi_fetch` = 1, an opcode fetch whose A15:A14 is 01 clears `paged`. With it at 0, or for other regions, such a fetch has no effect.
- R10: Port decoding compares only A7:A0. An I/O cycle with M1 low, which is an interrupt acknowledge, is ignored.
- R11: A strobe held low acts only once: re-arming during a held fetch from 0x0000 does not page in again.
- R12: `host_arm` sets the arm latch. `host_disarm` takes priority, clears the latch and clears `paged` at the next clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low reset |
| addr | input | 16 | Z80 address bus |
| m1_n | input | 1 | Opcode fetch strobe, active low |
| mreq_n | input | 1 | Memory request, active low |
| iorq_n | input | 1 | I/O request, active low |
| rd_n | input | 1 | Read strobe, active low |
| wr_n | input | 1 | Write strobe, active low |
| host_arm | input | 1 | Host pulse setting the arm latch |
| host_disarm | input | 1 | Host pulse clearing the latch and paging out |
| exit_hi_fetch | input | 1 | Enables page-out on fetch from 16–32 KB |
| rom_sel_n_in | input | 1 | System ROM select from the host decoder |
| rom_sel_n_out | output | 1 | ROM select after override |
| ram_sel_n | output | 1 | Debug RAM select, active low |
| comm_sel | output | 1 | Data channel port decoded |
| paged | output | 1 | Debug RAM mapped in |

## Verification
Paging results pass through two synchroniser flops and one edge register. The bench therefore applies each bus cycle just after a falling clock edge, waits three rising edges and samples 1 ns later, while the strobes are still held. The chip selects and `comm_sel` are combinational from the live bus and are sampled in that same window. Host disarm and arm act after one rising edge, and the bench samples those just after that edge. After each cycle the strobes are released and the bench idles three edges, so that the falling-edge detector has rearmed before the next cycle.

// File: rtl/z80pg_pkg.sv
package z80pg_pkg;
  localparam int ADDR_W = 16;
  localparam int PORT_W = 8;
  localparam int WIN_W  = 2;

  // Port decode sees only the low byte of the address bus.
  function automatic logic port_hit(input logic [ADDR_W-1:0] a,
                                    input logic [PORT_W-1:0] p);
    return a[PORT_W-1:0] == p;
  endfunction

  // Bottom 16 KB window.
  function automatic logic in_low_window(input logic [ADDR_W-1:0] a);
    return a[ADDR_W-1 -: WIN_W] == '0;
  endfunction

  // 16-32 KB region.
  function automatic logic in_second_window(input logic [ADDR_W-1:0] a);
    return a[ADDR_W-1 -: WIN_W] == WIN_W'(1);
  endfunction
endpackage

// File: rtl/z80pg_sync.sv
module z80pg_sync #(
  parameter int W      = 1,
  parameter int STAGES = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] pipe [STAGES];

  for (genvar g = 0; g < STAGES; g++) begin : g_stage
    if (g == 0) begin : g_first
      always_ff @(posedge clk or negedge rst_n)
        if (!rst_n) pipe[0] <= RST_VAL;
        else        pipe[0] <= d;
    end else begin : g_next
      always_ff @(posedge clk or negedge rst_n)
        if (!rst_n) pipe[g] <= RST_VAL;
        else        pipe[g] <= pipe[g-1];
    end
  end

  assign q = pipe[STAGES-1];
endmodule

// File: rtl/z80pg_decode.sv
module z80pg_decode
  import z80pg_pkg::*;
#(
  parameter logic [PORT_W-1:0] PAGE_PORT = 8'h9F
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] s_addr,
  input  logic              s_m1_n,
  input  logic              s_iorq_n,
  input  logic              s_rd_n,
  input  logic              s_wr_n,
  output logic              ev_fetch0,
  output logic              ev_hi_fetch,
  output logic              ev_io_rd_pg,
  output logic              ev_io_wr_pg
);
  logic fetch_lvl, iord_lvl, iowr_lvl;
  logic fetch_q, iord_q, iowr_q;
  logic fetch_fall, iord_fall, iowr_fall;

  assign fetch_lvl = !s_m1_n && s_iorq_n;
  assign iord_lvl  = !s_iorq_n && !s_rd_n && s_m1_n;
  assign iowr_lvl  = !s_iorq_n && !s_wr_n && s_m1_n;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) {fetch_q, iord_q, iowr_q} <= '0;
    else        {fetch_q, iord_q, iowr_q} <= {fetch_lvl, iord_lvl, iowr_lvl};

  assign fetch_fall = fetch_lvl && !fetch_q;
  assign iord_fall  = iord_lvl && !iord_q;
  assign iowr_fall  = iowr_lvl && !iowr_q;

  assign ev_fetch0   = fetch_fall && (s_addr == '0);
  assign ev_hi_fetch = fetch_fall && in_second_window(s_addr);
  assign ev_io_rd_pg = iord_fall && port_hit(s_addr, PAGE_PORT);
  assign ev_io_wr_pg = iowr_fall && port_hit(s_addr, PAGE_PORT);
endmodule

// File: rtl/z80pg_state.sv
module z80pg_state (
  input  logic clk,
  input  logic rst_n,
  input  logic host_arm,
  input  logic host_disarm,
  input  logic exit_hi_fetch,
  input  logic ev_fetch0,
  input  logic ev_hi_fetch,
  input  logic ev_io_rd_pg,
  input  logic ev_io_wr_pg,
  output logic armed,
  output logic paged
);
  logic go_out, go_in;

  assign go_out = ev_io_wr_pg || (ev_hi_fetch && exit_hi_fetch);
  assign go_in  = ev_fetch0 || ev_io_rd_pg;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)           armed <= 1'b0;
    else if (host_disarm) armed <= 1'b0;
    else if (host_arm)    armed <= 1'b1;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)                      paged <= 1'b0;
    else if (host_disarm || !armed)  paged <= 1'b0;
    else if (go_out)                 paged <= 1'b0;
    else if (go_in)                  paged <= 1'b1;
endmodule

// File: rtl/z80_page_ctrl.sv
module z80_page_ctrl
  import z80pg_pkg::*;
#(
  parameter logic [PORT_W-1:0] PAGE_PORT   = 8'h9F,
  parameter logic [PORT_W-1:0] COMM_PORT   = 8'h3F,
  parameter int                SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic              m1_n,
  input  logic              mreq_n,
  input  logic              iorq_n,
  input  logic              rd_n,
  input  logic              wr_n,
  input  logic              host_arm,
  input  logic              host_disarm,
  input  logic              exit_hi_fetch,
  input  logic              rom_sel_n_in,
  output logic              rom_sel_n_out,
  output logic              ram_sel_n,
  output logic              comm_sel,
  output logic              paged
);
  localparam int STRB_W = 4;

  logic [ADDR_W-1:0] s_addr;
  logic [STRB_W-1:0] s_strb;
  logic ev_fetch0, ev_hi_fetch, ev_io_rd_pg, ev_io_wr_pg;
  logic armed;
  logic low_win;

  z80pg_sync #(.W(ADDR_W), .STAGES(SYNC_STAGES), .RST_VAL('0)) i_sync_addr (
    .clk(clk), .rst_n(rst_n), .d(addr), .q(s_addr));

  z80pg_sync #(.W(STRB_W), .STAGES(SYNC_STAGES), .RST_VAL('1)) i_sync_strb (
    .clk(clk), .rst_n(rst_n), .d({m1_n, iorq_n, rd_n, wr_n}), .q(s_strb));

  z80pg_decode #(.PAGE_PORT(PAGE_PORT)) i_decode (
    .clk(clk), .rst_n(rst_n), .s_addr(s_addr),
    .s_m1_n(s_strb[3]), .s_iorq_n(s_strb[2]), .s_rd_n(s_strb[1]), .s_wr_n(s_strb[0]),
    .ev_fetch0(ev_fetch0), .ev_hi_fetch(ev_hi_fetch),
    .ev_io_rd_pg(ev_io_rd_pg), .ev_io_wr_pg(ev_io_wr_pg));

  z80pg_state i_state (
    .clk(clk), .rst_n(rst_n), .host_arm(host_arm), .host_disarm(host_disarm),
    .exit_hi_fetch(exit_hi_fetch), .ev_fetch0(ev_fetch0), .ev_hi_fetch(ev_hi_fetch),
    .ev_io_rd_pg(ev_io_rd_pg), .ev_io_wr_pg(ev_io_wr_pg),
    .armed(armed), .paged(paged));

  // Chip selects follow the live bus so memory timing is untouched.
  assign low_win       = in_low_window(addr);
  assign ram_sel_n     = !(paged && !mreq_n && low_win);
  assign rom_sel_n_out = (paged && low_win) ? 1'b1 : rom_sel_n_in;
  assign comm_sel      = !iorq_n && m1_n && (!rd_n || !wr_n) && port_hit(addr, COMM_PORT);
endmodule

// File: rtl/z80pg_checker.sv
module z80pg_checker
  import z80pg_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic [ADDR_W-1:0] addr,
  input logic              rom_sel_n_in,
  input logic              rom_sel_n_out,
  input logic              ram_sel_n,
  input logic              paged,
  input logic              armed,
  input logic              host_disarm,
  input logic              exit_hi_fetch,
  input logic              ev_fetch0,
  input logic              ev_hi_fetch,
  input logic              ev_io_rd_pg,
  input logic              ev_io_wr_pg
);
  assert_unarmed_paged_out_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !armed |-> !paged);
  assert_fetch0_pages_in_R3: assert property (@(posedge clk) disable iff (!rst_n)
    ev_fetch0 && armed && !host_disarm |=> paged);
  assert_port_rd_pages_in_R4: assert property (@(posedge clk) disable iff (!rst_n)
    ev_io_rd_pg && armed && !host_disarm |=> paged);
  assert_port_wr_pages_out_R5: assert property (@(posedge clk) disable iff (!rst_n)
    ev_io_wr_pg |=> !paged);
  assert_ram_rom_exclusive_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !ram_sel_n |-> rom_sel_n_out);
  assert_rom_passthrough_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !in_low_window(addr) |-> rom_sel_n_out == rom_sel_n_in);
  assert_hi_fetch_exit_R9: assert property (@(posedge clk) disable iff (!rst_n)
    ev_hi_fetch && exit_hi_fetch |=> !paged);
  assert_single_event_R11: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({ev_fetch0, ev_hi_fetch, ev_io_rd_pg, ev_io_wr_pg}));
  assert_disarm_forces_out_R12: assert property (@(posedge clk) disable iff (!rst_n)
    host_disarm |=> !paged && !armed);
endmodule

bind z80_page_ctrl z80pg_checker i_chk (
  .clk(clk), .rst_n(rst_n), .addr(addr), .rom_sel_n_in(rom_sel_n_in),
  .rom_sel_n_out(rom_sel_n_out), .ram_sel_n(ram_sel_n), .paged(paged),
  .armed(armed), .host_disarm(host_disarm), .exit_hi_fetch(exit_hi_fetch),
  .ev_fetch0(ev_fetch0), .ev_hi_fetch(ev_hi_fetch),
  .ev_io_rd_pg(ev_io_rd_pg), .ev_io_wr_pg(ev_io_wr_pg));

// File: tb/test_z80_page_ctrl.sv
`timescale 1ns/1ps
module test_z80_page_ctrl;
  localparam logic [1:0] K_FETCH = 2'd0, K_IORD = 2'd1, K_IOWR = 2'd2, K_MEMRD = 2'd3;
  localparam int NV = 10;
  // {addr, kind, expected paged, expected comm_sel}
  localparam logic [19:0] VEC [NV] = '{
    {16'h8000, K_FETCH, 1'b0, 1'b0},
    {16'h003F, K_IORD,  1'b0, 1'b1},
    {16'h129F, K_IORD,  1'b1, 1'b0},
    {16'h009F, K_IOWR,  1'b0, 1'b0},
    {16'h0000, K_FETCH, 1'b1, 1'b0},
    {16'h4000, K_FETCH, 1'b1, 1'b0},
    {16'h553F, K_IOWR,  1'b1, 1'b1},
    {16'h559F, K_IOWR,  1'b0, 1'b0},
    {16'h0000, K_MEMRD, 1'b0, 1'b0},
    {16'h0001, K_FETCH, 1'b0, 1'b0}
  };

  logic clk = 1'b0, rst_n = 1'b0;
  logic [15:0] addr = '0;
  logic m1_n = 1, mreq_n = 1, iorq_n = 1, rd_n = 1, wr_n = 1;
  logic host_arm = 0, host_disarm = 0, exit_hi_fetch = 0, rom_sel_n_in = 0;
  logic rom_sel_n_out, ram_sel_n, comm_sel, paged;
  int checks = 0, errors = 0;
  bit done = 0;

  always #2 clk = ~clk;

  z80_page_ctrl i_z80_page_ctrl (
    .clk(clk), .rst_n(rst_n), .addr(addr), .m1_n(m1_n), .mreq_n(mreq_n),
    .iorq_n(iorq_n), .rd_n(rd_n), .wr_n(wr_n), .host_arm(host_arm),
    .host_disarm(host_disarm), .exit_hi_fetch(exit_hi_fetch),
    .rom_sel_n_in(rom_sel_n_in), .rom_sel_n_out(rom_sel_n_out),
    .ram_sel_n(ram_sel_n), .comm_sel(comm_sel), .paged(paged));

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic drive(input logic [1:0] k, input logic [15:0] a);
    @(negedge clk);
    addr = a;
    case (k)
      K_FETCH: begin m1_n = 0; mreq_n = 0; rd_n = 0; end
      K_IORD:  begin iorq_n = 0; rd_n = 0; end
      K_IOWR:  begin iorq_n = 0; wr_n = 0; end
      default: begin mreq_n = 0; rd_n = 0; end
    endcase
    repeat (3) @(posedge clk);
    #1;
  endtask

  task automatic idle();
    @(negedge clk);
    {m1_n, mreq_n, iorq_n, rd_n, wr_n} = '1;
    repeat (3) @(posedge clk);
    #1;
  endtask

  task automatic host_pulse(input bit arm, input bit disarm);
    @(negedge clk);
    host_arm = arm; host_disarm = disarm;
    @(posedge clk); #1;
    host_arm = 0; host_disarm = 0;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  initial begin
    #(4ns * 100000);
    checks++; errors++;
    $display("FAIL watchdog expired actual 0 expected 1");
    finish_run();
  end

  initial begin
    repeat (4) @(posedge clk);
    @(negedge clk) rst_n = 1;
    @(posedge clk); #1;
    // R1 reset state
    check("R1 paged", paged, 0);
    check("R1 ram_sel_n", ram_sel_n, 1);
    check("R1 rom passthrough", rom_sel_n_out, 0);
    // R2 no paging while disarmed
    drive(K_FETCH, 16'h0000); check("R2 fetch0 disarmed", paged, 0); idle();
    drive(K_IORD, 16'h009F);  check("R2 port read disarmed", paged, 0); idle();
    // R12 arm
    host_pulse(1, 0);
    // Table walk: R3 R4 R5 R6 R9 R10
    for (int i = 0; i < NV; i++) begin
      drive(VEC[i][3:2], VEC[i][19:4]);
      check($sformatf("R3-R6/R9/R10 vec %0d paged", i), paged, VEC[i][1]);
      check($sformatf("R6 vec %0d comm_sel", i), comm_sel, VEC[i][0]);
      idle();
    end
    // R7 / R8 chip selects while paged
    drive(K_IORD, 16'h009F); idle();
    drive(K_MEMRD, 16'h3FFF);
    check("R7 ram_sel_n low window", ram_sel_n, 0);
    check("R7 rom_sel_n_out forced", rom_sel_n_out, 1);
    idle();
    check("R7 ram_sel_n without MREQ", ram_sel_n, 1);
    drive(K_MEMRD, 16'h4000);
    check("R8 ram_sel_n above window", ram_sel_n, 1);
    check("R8 rom passthrough 0", rom_sel_n_out, 0);
    rom_sel_n_in = 1; #1;
    check("R8 rom passthrough 1", rom_sel_n_out, 1);
    rom_sel_n_in = 0;
    idle();
    // R9 mode on: 8000 region ignored, 4000 region exits
    exit_hi_fetch = 1;
    drive(K_FETCH, 16'h8123); check("R9 other region no exit", paged, 1); idle();
    drive(K_FETCH, 16'h4567); check("R9 exit on 16-32K fetch", paged, 0); idle();
    exit_hi_fetch = 0;
    // R10 interrupt acknowledge at port address ignored
    @(negedge clk); addr = 16'h009F; m1_n = 0; iorq_n = 0; rd_n = 0;
    repeat (3) @(posedge clk); #1;
    check("R10 int ack ignored", paged, 0);
    idle();
    // R11 held fetch does not retrigger after rearm; R12 disarm forces out
    drive(K_FETCH, 16'h0000);
    check("R11 fetch0 pages in", paged, 1);
    host_pulse(0, 1);
    check("R12 disarm forces out", paged, 0);
    host_pulse(1, 0);
    repeat (4) @(posedge clk); #1;
    check("R11 held strobe no retrigger", paged, 0);
    idle();
    drive(K_FETCH, 16'h0000); check("R11 new cycle pages in", paged, 1); idle();
    finish_run();
  end
endmodule